// File: doc/BRIEF.md
# I2C Controller Transfer FIFO Pair with Receive Watermark

This block holds the two data queues that sit between the register interface of an I2C controller and its bit engine. Software writes outgoing entries through a 16-bit data port into a 10-bit wide transmit queue. The bit engine consumes those entries from the queue head. In the other direction, the engine pushes received bytes into an 8-bit receive queue. Software then reads them back one byte per access.

Both queues hold 16 entries. Each queue reports its fill level in a zero-based form: the reported value is the number of stored entries minus one, and it reads zero when the queue is empty. The transmit side raises an empty indication and a half-empty indication. The receive side compares its fill level against a programmable zero-based watermark and raises a level signal once enough bytes have arrived. A flush control empties the transmit queue and keeps it empty while it is held.

Top module: `i2c_xfer_fifos`

## Requirements
- R1: After synchronous reset both queues are empty: `tx_empty`=1, `tx_half`=1, `rx_empty`=1, both full flags 0, both occupancy outputs 0, the watermark holds 15 and `rx_wm_hit`=0.
- R2: Each queue returns entries in the order they were accepted. A transmit entry is bits [9:0] of the 16-bit write word, and bits [15:10] are dropped.
- R3: Each occupancy output equals the stored count minus one when the count is 1 to 16, and 0 when the count is 0. The full flag is 1 exactly at 16 entries and the empty flag is 1 exactly at 0 entries.
- R4: A push to a full queue (software write to transmit, engine push to receive) is ignored. The count stays at 16 and the stored entries are unchanged.
- R5: A pop from an empty queue (software read of receive, engine pop of transmit) is ignored. The count stays 0 and later data is unaffected.
- R6: With watermark value N written through `wm_wr_en`/`wm_wr_data`, `rx_wm_hit` is 1 exactly when the receive count is at least N+1. Writing 15 means the signal is 1 only when the queue is completely full.
- R7: `tx_half` is 1 exactly when the transmit count is 8 or less, and `tx_empty` is 1 exactly when it is 0.
- R8: At the first clock edge that samples `tx_flush`=1, the transmit queue becomes empty. It stays empty, with writes ignored, for as long as `tx_flush` remains 1.
- R9: Each accepted receive read removes exactly one entry. Reading until `rx_empty` is set takes exactly as many reads as there were stored entries.
- R10: A push and a pop in the same cycle on a queue that is neither empty nor full leave its count unchanged, and both operations take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_wr_en | input | 1 | Software write to the transmit queue |
| tx_wr_data | input | 16 | Write word; bits [9:0] are stored |
| tx_flush | input | 1 | Transmit queue flush (level) |
| tx_pop | input | 1 | Bit engine consumes the transmit head |
| tx_head | output | 10 | Transmit queue head entry |
| rx_push | input | 1 | Bit engine delivers a received byte |
| rx_push_data | input | 8 | Received byte |
| rx_rd_en | input | 1 | Software read of the receive queue (pops one) |
| rx_rd_data | output | 8 | Receive queue head byte |
| wm_wr_en | input | 1 | Write the receive watermark |
| wm_wr_data | input | 4 | Zero-based watermark value |
| tx_occ | output | 4 | Transmit occupancy, count minus one |
| rx_occ | output | 4 | Receive occupancy, count minus one |
| tx_full | output | 1 | Transmit queue holds 16 entries |
| tx_empty | output | 1 | Transmit queue holds no entries |
| tx_half | output | 1 | Transmit count is 8 or less |
| rx_full | output | 1 | Receive queue holds 16 entries |
| rx_empty | output | 1 | Receive queue holds no entries |
| rx_wm_hit | output | 1 | Receive count has reached watermark plus one |

## Verification
The bench pushes a 17th entry into a full transmit queue. A design that let it through would wrap its write pointer over the oldest entry, and the drained data would come out in the wrong order. The bench reads from an empty receive queue and then checks that later bytes arrive intact, which catches a read pointer that moves on an empty pop. It sweeps the watermark from 0 to 15 and checks the boundary counts N and N+1, so an off-by-one comparison that fires at N shows up. It holds the flush active while writing and checks that nothing is stored. It also mixes random same-cycle pushes and pops, so a queue that drops one operation is caught by a count that drifts.

// File: rtl/i2c_xfer_fifo_pkg.sv
package i2c_xfer_fifo_pkg;

    parameter int unsigned QDEPTH    = 16;
    parameter int unsigned TXE_W     = 10;
    parameter int unsigned RXE_W     = 8;
    parameter int unsigned WPORT_W   = 16;

    localparam int unsigned CNT_W    = $clog2(QDEPTH + 1);
    localparam int unsigned OCC_W    = $clog2(QDEPTH);
    localparam int unsigned HALF_LVL = QDEPTH / 2;

    typedef struct packed {
        logic full;
        logic empty;
    } q_flags_t;

    // Zero-based occupancy: count minus one, clamped to zero when empty.
    function automatic logic [OCC_W-1:0] occ_of(input logic [CNT_W-1:0] cnt);
        logic [CNT_W-1:0] m1;
        m1 = cnt - CNT_W'(1);
        return (cnt == '0) ? '0 : m1[OCC_W-1:0];
    endfunction

endpackage

// File: rtl/xfer_queue.sv
module xfer_queue
    import i2c_xfer_fifo_pkg::*;
#(
    parameter int unsigned EW    = 8,
    parameter int unsigned DEPTH = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic                push,
    input  logic [EW-1:0]       push_data,
    input  logic                pop,
    output logic [EW-1:0]       head,
    output logic [CNT_W-1:0]    count,
    output q_flags_t            flags
);
    localparam int unsigned AW = $clog2(DEPTH);

    logic [EW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign flags.full  = (count == CNT_W'(DEPTH));
    assign flags.empty = (count == '0);

    // Full is judged before any same-cycle pop; clear blocks everything.
    assign do_push = push && !flags.full  && !clear;
    assign do_pop  = pop  && !flags.empty && !clear;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    assign head = mem[rd_ptr];

    // R3: count never exceeds the depth
    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R4: push into full without pop leaves count at depth
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (flags.full && push && !pop && !clear) |=> (count == CNT_W'(DEPTH)));

    // R5: pop from empty without push leaves it empty
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (flags.empty && pop && !push && !clear) |=> flags.empty);

    // R8: clear empties the queue at the next edge
    a_r8_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clear |=> (count == '0));

    // R10: simultaneous push and pop in the middle keep the count
    a_r10_push_pop_hold: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !flags.full && !flags.empty && !clear) |=> $stable(count));

endmodule

// File: rtl/tx_level_unit.sv
module tx_level_unit
    import i2c_xfer_fifo_pkg::*;
#(
    parameter int unsigned HALF = HALF_LVL
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count,
    output logic             lvl_empty,
    output logic             lvl_half
);
    assign lvl_empty = (count == '0);
    assign lvl_half  = (count <= CNT_W'(HALF));

    // R7: an empty queue is also at or below half
    a_r7_empty_is_half: assert property (@(posedge clk) disable iff (rst)
        lvl_empty |-> lvl_half);

endmodule

// File: rtl/rx_watermark_unit.sv
module rx_watermark_unit
    import i2c_xfer_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = QDEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wm_wr,
    input  logic [OCC_W-1:0] wm_data,
    input  logic [CNT_W-1:0] count,
    output logic             hit
);
    logic [OCC_W-1:0] wm_q;
    logic [CNT_W-1:0] thresh;

    always_ff @(posedge clk) begin
        if (rst) begin
            wm_q <= OCC_W'(DEPTH - 1);
        end else if (wm_wr) begin
            wm_q <= wm_data;
        end
    end

    // Zero-based watermark: N means N+1 entries.
    assign thresh = CNT_W'(wm_q) + CNT_W'(1);
    assign hit    = (count >= thresh);

    // R6: an empty queue never meets any watermark
    a_r6_empty_no_hit: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |-> !hit);

    // R6: a full queue meets every watermark
    a_r6_full_hit: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_W'(DEPTH)) |-> hit);

endmodule

// File: rtl/i2c_xfer_fifos.sv
module i2c_xfer_fifos
    import i2c_xfer_fifo_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tx_wr_en,
    input  logic [WPORT_W-1:0] tx_wr_data,
    input  logic               tx_flush,
    input  logic               tx_pop,
    output logic [TXE_W-1:0]   tx_head,
    input  logic               rx_push,
    input  logic [RXE_W-1:0]   rx_push_data,
    input  logic               rx_rd_en,
    output logic [RXE_W-1:0]   rx_rd_data,
    input  logic               wm_wr_en,
    input  logic [OCC_W-1:0]   wm_wr_data,
    output logic [OCC_W-1:0]   tx_occ,
    output logic [OCC_W-1:0]   rx_occ,
    output logic               tx_full,
    output logic               tx_empty,
    output logic               tx_half,
    output logic               rx_full,
    output logic               rx_empty,
    output logic               rx_wm_hit
);
    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    q_flags_t         tx_flg, rx_flg;
    logic             tx_lvl_empty;

    xfer_queue #(.EW(TXE_W), .DEPTH(QDEPTH)) u_txq (
        .clk       (clk),
        .rst       (rst),
        .clear     (tx_flush),
        .push      (tx_wr_en),
        .push_data (tx_wr_data[TXE_W-1:0]),
        .pop       (tx_pop),
        .head      (tx_head),
        .count     (tx_cnt),
        .flags     (tx_flg)
    );

    xfer_queue #(.EW(RXE_W), .DEPTH(QDEPTH)) u_rxq (
        .clk       (clk),
        .rst       (rst),
        .clear     (1'b0),
        .push      (rx_push),
        .push_data (rx_push_data),
        .pop       (rx_rd_en),
        .head      (rx_rd_data),
        .count     (rx_cnt),
        .flags     (rx_flg)
    );

    tx_level_unit #(.HALF(HALF_LVL)) u_txlvl (
        .clk       (clk),
        .rst       (rst),
        .count     (tx_cnt),
        .lvl_empty (tx_lvl_empty),
        .lvl_half  (tx_half)
    );

    rx_watermark_unit #(.DEPTH(QDEPTH)) u_rxwm (
        .clk     (clk),
        .rst     (rst),
        .wm_wr   (wm_wr_en),
        .wm_data (wm_wr_data),
        .count   (rx_cnt),
        .hit     (rx_wm_hit)
    );

    assign tx_occ   = occ_of(tx_cnt);
    assign rx_occ   = occ_of(rx_cnt);
    assign tx_full  = tx_flg.full;
    assign tx_empty = tx_lvl_empty;
    assign rx_full  = rx_flg.full;
    assign rx_empty = rx_flg.empty;

    // R7: level unit and queue agree on emptiness
    a_r7_empty_agree: assert property (@(posedge clk) disable iff (rst)
        tx_empty == tx_flg.empty);

    // R8: a held flush keeps the transmit queue empty
    a_r8_flush_held: assert property (@(posedge clk) disable iff (rst)
        (tx_flush && $past(tx_flush)) |-> tx_empty);

endmodule

// File: tb/i2c_xfer_fifos_bench.sv
`timescale 1ns/1ps
module i2c_xfer_fifos_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        tx_wr_en, tx_flush, tx_pop, rx_push, rx_rd_en, wm_wr_en;
    logic [15:0] tx_wr_data;
    logic [7:0]  rx_push_data;
    logic [3:0]  wm_wr_data;
    logic [9:0]  tx_head;
    logic [7:0]  rx_rd_data;
    logic [3:0]  tx_occ, rx_occ;
    logic        tx_full, tx_empty, tx_half, rx_full, rx_empty, rx_wm_hit;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          done  = 0;

    int unsigned txq[$];
    int unsigned rxq[$];
    int unsigned wm_m = 15;

    always #2.5 clk = ~clk;

    i2c_xfer_fifos u_i2c_xfer_fifos (
        .clk(clk), .rst(rst),
        .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data), .tx_flush(tx_flush),
        .tx_pop(tx_pop), .tx_head(tx_head),
        .rx_push(rx_push), .rx_push_data(rx_push_data),
        .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data),
        .wm_wr_en(wm_wr_en), .wm_wr_data(wm_wr_data),
        .tx_occ(tx_occ), .rx_occ(rx_occ),
        .tx_full(tx_full), .tx_empty(tx_empty), .tx_half(tx_half),
        .rx_full(rx_full), .rx_empty(rx_empty), .rx_wm_hit(rx_wm_hit)
    );

    function automatic int unsigned exp_occ(int unsigned n);
        return (n == 0) ? 0 : n - 1;
    endfunction

    task automatic chk(string req, int unsigned act, int unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk("R3 tx_occ",   tx_occ,   exp_occ(txq.size()));
        chk("R3 rx_occ",   rx_occ,   exp_occ(rxq.size()));
        chk("R3 tx_full",  tx_full,  txq.size() == 16);
        chk("R3 rx_full",  rx_full,  rxq.size() == 16);
        chk("R7 tx_empty", tx_empty, txq.size() == 0);
        chk("R9 rx_empty", rx_empty, rxq.size() == 0);
        chk("R7 tx_half",  tx_half,  txq.size() <= 8);
        chk("R6 rx_wm_hit", rx_wm_hit, rxq.size() >= wm_m + 1);
    endtask

    // Drive one cycle of stimulus, update the model at the edge, check after.
    task automatic cyc(bit twr, logic [15:0] tdat, bit tpop, bit fl,
                       bit rps, logic [7:0] rdat, bit rrd, bit wmw, logic [3:0] wmd);
        bit tpush_ok, tpop_ok, rpush_ok, rpop_ok;
        tx_wr_en = twr; tx_wr_data = tdat; tx_pop = tpop; tx_flush = fl;
        rx_push = rps; rx_push_data = rdat; rx_rd_en = rrd;
        wm_wr_en = wmw; wm_wr_data = wmd;
        #0.5;
        if (tpop && txq.size() > 0 && !fl) chk("R2 tx_head", tx_head, txq[0]);
        if (rrd && rxq.size() > 0) chk("R2 rx_rd_data", rx_rd_data, rxq[0]);
        @(posedge clk);
        if (fl) begin
            txq.delete();
        end else begin
            tpush_ok = twr && txq.size() < 16;
            tpop_ok  = tpop && txq.size() > 0;
            if (tpop_ok)  void'(txq.pop_front());
            if (tpush_ok) txq.push_back(int'(tdat[9:0]));
        end
        rpush_ok = rps && rxq.size() < 16;
        rpop_ok  = rrd && rxq.size() > 0;
        if (rpop_ok)  void'(rxq.pop_front());
        if (rpush_ok) rxq.push_back(int'(rdat));
        if (wmw) wm_m = wmd;
        @(negedge clk);
        check_all();
    endtask

    task automatic idle();
        cyc(0, 16'h0, 0, 0, 0, 8'h0, 0, 0, 4'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int unsigned reads;
        void'($urandom(32'd4321));
        rst = 1'b1;
        tx_wr_en = 0; tx_wr_data = 0; tx_flush = 0; tx_pop = 0;
        rx_push = 0; rx_push_data = 0; rx_rd_en = 0; wm_wr_en = 0; wm_wr_data = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1: reset state
        chk("R1 tx_empty", tx_empty, 1); chk("R1 tx_half", tx_half, 1);
        chk("R1 rx_empty", rx_empty, 1); chk("R1 tx_occ", tx_occ, 0);
        chk("R1 rx_occ", rx_occ, 0);     chk("R1 rx_wm_hit", rx_wm_hit, 0);
        chk("R1 tx_full", tx_full, 0);   chk("R1 rx_full", rx_full, 0);

        // R4: seventeen writes, the last ignored; upper bits dropped (R2)
        for (int i = 0; i < 17; i++) cyc(1, 16'hFC00 | 16'(i * 37), 0, 0, 0, 0, 0, 0, 0);
        chk("R4 tx_full after extra write", tx_full, 1);
        for (int i = 0; i < 16; i++) cyc(0, 0, 1, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 0, 0, 0, 0);  // R5: pop from empty transmit

        // R5: reads from empty receive, then fresh data intact
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 1, 8'hA5, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 0);
        chk("R5 rx_empty after readback", rx_empty, 1);

        // R6: watermark sweep, boundary at N and N+1 fills
        for (int n = 0; n < 16; n++) begin
            cyc(0, 0, 0, 0, 0, 0, 0, 1, 4'(n));
            for (int k = 0; k <= n; k++) begin
                chk("R6 below watermark", rx_wm_hit, 0);
                cyc(0, 0, 0, 0, 1, 8'(k + n), 0, 0, 0);
            end
            chk("R6 at watermark", rx_wm_hit, 1);
            // R9: drain counting reads until empty
            reads = 0;
            while (!rx_empty && reads < 40) begin
                cyc(0, 0, 0, 0, 0, 0, 1, 0, 0);
                reads++;
            end
            chk("R9 drain read count", reads, n + 1);
        end
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 4'd15);
        for (int k = 0; k < 17; k++) cyc(0, 0, 0, 0, 1, 8'(k), 0, 0, 0);
        chk("R4 rx stays full", rx_occ, 15);
        for (int k = 0; k < 16; k++) cyc(0, 0, 0, 0, 0, 0, 1, 0, 0);

        // R8: flush held while writing
        for (int i = 0; i < 5; i++) cyc(1, 16'(i + 100), 0, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) begin
            cyc(1, 16'h3FF, 0, 1, 0, 0, 0, 0, 0);
            chk("R8 empty under flush", tx_empty, 1);
        end
        cyc(1, 16'h011, 0, 0, 0, 0, 0, 0, 0);
        cyc(1, 16'h022, 0, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 0, 0, 0, 0);

        // R10: simultaneous push and pop in the middle
        for (int i = 0; i < 6; i++) cyc(1, 16'(i), 0, 0, 1, 8'(i), 0, 0, 0);
        for (int i = 0; i < 8; i++) begin
            cyc(1, 16'(200 + i), 1, 0, 1, 8'(50 + i), 1, 0, 0);
            chk("R10 tx count held", tx_occ, 5);
            chk("R10 rx count held", rx_occ, 5);
        end

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            cyc(($urandom % 3) != 0, 16'($urandom), ($urandom % 3) == 0,
                ($urandom % 60) == 0, ($urandom % 2) == 0, 8'($urandom),
                ($urandom % 2) == 0, ($urandom % 25) == 0, 4'($urandom));
        end
        idle();
        finish_run();
    end
endmodule